// File: doc/BRIEF.md
# Root Hub Port Status and Control Registers

This block holds the per-port status and control words of a small root hub (two ports by default). Each port has one 16-bit word. The word combines three kinds of bit:

- live line and device levels taken from a port PHY abstraction, which are read-only;
- control bits that software writes, which drive the port's enable, reset and suspend outputs;
- sticky change flags, which hardware sets and software clears by writing 1.

Software reaches the words through a simple register bus. Port `p` sits at byte offset `BASE_ADDR + 2*p`, which is 0x10 and 0x12 by default. Writes are single-cycle and take effect at the clock edge. Reads are registered and return data one cycle after the request.

A combined change output tells the host when any port has a pending connect or enable change. The block does not generate the actual bus signalling or time the reset pulse. It only holds the bits that request them.

Top module: `hub_port_regs`

## Requirements
- R1: Port `p` is decoded only at byte address `BASE_ADDR + 2*p` (0x10 and 0x12 by default). Reads of any other address, including odd addresses, return 0x0000. Writes to any other address change no port state.
- R2: The following bits are read-only and show the current port inputs: bit 0 is connect, bit 4 is the D- level, bit 5 is the D+ level, bit 6 is resume-detected, and bit 8 is low-speed. Written values for these bits have no effect.
- R3: When the connect input differs from the value sampled at the previous edge, bit 1 (connect changed) is set at the next edge. The sampled value is 0 after reset.
- R4: For bit 1 and bit 3, writing 1 clears the bit and writing 0 leaves it unchanged. If the setting event occurs in the same cycle as the clearing write, the bit stays set.
- R5: Bit 2 (port enable) takes the written value only while the connect input is 1. A write of 1 while disconnected leaves it 0. Bit 2 drives `port_enable`.
- R6: A disconnect while the port is enabled clears bit 2 and sets bit 3 (enable changed) at the next edge. A software write that clears bit 2 does not set bit 3.
- R7: Bit 9 (port reset) and bit 12 (port suspend) are read/write. They drive `port_reset` and `port_suspend`.
- R8: A write with `wr_be` other than 2'b11 is ignored.
- R9: Bits 7, 10, 11, 13, 14 and 15 always read as 0.
- R10: `change_any` is 1 exactly when bit 1 or bit 3 of any port is set.
- R11: A read request at an edge places the word, as it stood just before that edge, on `rd_data` at that edge. `rd_data` holds its value while `rd_en` is 0. Reads have no side effects.
- R12: Synchronous active-high reset clears every stored bit, `rd_data` and all control outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address for the read or write |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 2 | Byte enables; only 2'b11 writes |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| phy_connect | input | NUM_PORTS | Device-present level per port |
| phy_low_speed | input | NUM_PORTS | Low-speed device level per port |
| phy_dplus | input | NUM_PORTS | D+ line level per port |
| phy_dminus | input | NUM_PORTS | D- line level per port |
| phy_resume | input | NUM_PORTS | Resume-detected level per port |
| port_enable | output | NUM_PORTS | Port enable control |
| port_reset | output | NUM_PORTS | Port reset control |
| port_suspend | output | NUM_PORTS | Port suspend control |
| change_any | output | 1 | Any port has a change flag set |

## Verification
The results fall into two timing groups:

- **Due one edge after the stimulus:** the control outputs, the change flags and `change_any`.
- **Due at the edge of the read:** a read returns the word as it stood before that edge, so the effect of a write or an input change appears on `rd_data` only through a read issued at a later edge.

The bench drives every input between edges and applies one edge per step. It samples one time unit after that edge. It therefore always compares against the state that the last completed edge produced. Same-cycle collisions between an event and a clearing write are staged by changing the input in the very cycle of the write.

// File: rtl/hub_port_pkg.sv
package hub_port_pkg;

    localparam int unsigned WORD_W = 16;

    // Bit positions inside a port word (software decodes these)
    localparam int unsigned B_CONN = 0;
    localparam int unsigned B_CSC  = 1;
    localparam int unsigned B_EN   = 2;
    localparam int unsigned B_ENC  = 3;
    localparam int unsigned B_DM   = 4;
    localparam int unsigned B_DP   = 5;
    localparam int unsigned B_RSM  = 6;
    localparam int unsigned B_LS   = 8;
    localparam int unsigned B_RST  = 9;
    localparam int unsigned B_SUSP = 12;

    // Bits that may read as 1; everything else reads 0
    localparam logic [WORD_W-1:0] LIVE_MASK =
        (WORD_W'(1) << B_CONN) | (WORD_W'(1) << B_CSC) | (WORD_W'(1) << B_EN)  |
        (WORD_W'(1) << B_ENC)  | (WORD_W'(1) << B_DM)  | (WORD_W'(1) << B_DP)  |
        (WORD_W'(1) << B_RSM)  | (WORD_W'(1) << B_LS)  | (WORD_W'(1) << B_RST) |
        (WORD_W'(1) << B_SUSP);

    // Decoded write command for one port
    typedef struct packed {
        logic clr_csc;
        logic clr_enc;
        logic enable;
        logic hold_reset;
        logic suspend;
    } port_wr_t;

    // Observable state of one port
    typedef struct packed {
        logic suspend;
        logic hold_reset;
        logic low_speed;
        logic resume;
        logic dplus;
        logic dminus;
        logic enc;
        logic enable;
        logic csc;
        logic conn;
    } port_view_t;

    function automatic logic [WORD_W-1:0] pack_view(input port_view_t v);
        logic [WORD_W-1:0] w;
        w         = '0;
        w[B_CONN] = v.conn;
        w[B_CSC]  = v.csc;
        w[B_EN]   = v.enable;
        w[B_ENC]  = v.enc;
        w[B_DM]   = v.dminus;
        w[B_DP]   = v.dplus;
        w[B_RSM]  = v.resume;
        w[B_LS]   = v.low_speed;
        w[B_RST]  = v.hold_reset;
        w[B_SUSP] = v.suspend;
        return w;
    endfunction

endpackage

// File: rtl/hub_port_decode.sv
module hub_port_decode #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BASE_ADDR = 16,
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned IDX_W     = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned SPAN = 2 * NUM_PORTS;

    logic [ADDR_W-1:0] off;
    logic              unused_off_hi;

    // Wrap-around of the subtraction rejects addresses below the base
    always_comb begin
        off = addr - ADDR_W'(BASE_ADDR);
        hit = (off < ADDR_W'(SPAN)) && !off[0];
        idx = off[IDX_W:1];
    end

    assign unused_off_hi = ^off[ADDR_W-1:IDX_W+1];

endmodule

// File: rtl/hub_port_slot.sv
module hub_port_slot
    import hub_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_sel,
    input  port_wr_t   wr_cmd,
    input  logic       phy_connect,
    input  logic       phy_low_speed,
    input  logic       phy_dplus,
    input  logic       phy_dminus,
    input  logic       phy_resume,
    output port_view_t view,
    output logic       change
);
    logic conn_q, csc_q, en_q, enc_q, hrst_q, susp_q;
    logic conn_evt, en_drop;
    logic nxt_csc, nxt_en, nxt_enc, nxt_hrst, nxt_susp;

    always_comb begin
        conn_evt = phy_connect ^ conn_q;
        en_drop  = en_q & ~phy_connect;
        // a hardware event in the same cycle wins over a clearing write
        nxt_csc  = conn_evt | (csc_q & ~(wr_sel & wr_cmd.clr_csc));
        nxt_enc  = en_drop  | (enc_q & ~(wr_sel & wr_cmd.clr_enc));
        // enable only holds while a device is present
        nxt_en   = (wr_sel ? wr_cmd.enable : en_q) & phy_connect;
        nxt_hrst = wr_sel ? wr_cmd.hold_reset : hrst_q;
        nxt_susp = wr_sel ? wr_cmd.suspend    : susp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            conn_q <= 1'b0;
            csc_q  <= 1'b0;
            en_q   <= 1'b0;
            enc_q  <= 1'b0;
            hrst_q <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            conn_q <= phy_connect;
            csc_q  <= nxt_csc;
            en_q   <= nxt_en;
            enc_q  <= nxt_enc;
            hrst_q <= nxt_hrst;
            susp_q <= nxt_susp;
        end
    end

    always_comb begin
        view.conn       = phy_connect;
        view.csc        = csc_q;
        view.enable     = en_q;
        view.enc        = enc_q;
        view.dminus     = phy_dminus;
        view.dplus      = phy_dplus;
        view.resume     = phy_resume;
        view.low_speed  = phy_low_speed;
        view.hold_reset = hrst_q;
        view.suspend    = susp_q;
        change          = csc_q | enc_q;
    end

    a_r3_conn_edge_flags: assert property (@(posedge clk) disable iff (rst)
        (phy_connect != conn_q) |=> csc_q);

    a_r4_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
        (csc_q && !(wr_sel && wr_cmd.clr_csc)) |=> csc_q);

    a_r5_enable_needs_device: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> $past(phy_connect));

    a_r6_disconnect_drops: assert property (@(posedge clk) disable iff (rst)
        (en_q && !phy_connect) |=> (!en_q && enc_q));

endmodule

// File: rtl/hub_port_rdmux.sv
module hub_port_rdmux
    import hub_port_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned IDX_W     = 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rd_en,
    input  logic                            hit,
    input  logic [IDX_W-1:0]                idx,
    input  port_view_t [NUM_PORTS-1:0]      views,
    output logic [WORD_W-1:0]               rd_data
);
    logic [WORD_W-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        if (hit) sel_word = pack_view(views[idx]);
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= sel_word;
    end

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~LIVE_MASK) == '0);

endmodule

// File: rtl/hub_port_regs.sv
module hub_port_regs
    import hub_port_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BASE_ADDR = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 wr_en,
    input  logic [1:0]           wr_be,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 rd_en,
    output logic [WORD_W-1:0]    rd_data,
    input  logic [NUM_PORTS-1:0] phy_connect,
    input  logic [NUM_PORTS-1:0] phy_low_speed,
    input  logic [NUM_PORTS-1:0] phy_dplus,
    input  logic [NUM_PORTS-1:0] phy_dminus,
    input  logic [NUM_PORTS-1:0] phy_resume,
    output logic [NUM_PORTS-1:0] port_enable,
    output logic [NUM_PORTS-1:0] port_reset,
    output logic [NUM_PORTS-1:0] port_suspend,
    output logic                 change_any
);
    localparam int unsigned IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic                          hit;
    logic [IDX_W-1:0]              idx;
    logic                          wr_ok;
    port_wr_t                      wr_cmd;
    port_view_t [NUM_PORTS-1:0]    views;
    logic [NUM_PORTS-1:0]          wr_sel;
    logic [NUM_PORTS-1:0]          change;
    logic                          unused_wr_bits;

    hub_port_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .NUM_PORTS(NUM_PORTS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr(bus_addr),
        .hit (hit),
        .idx (idx)
    );

    // only full-word writes count
    always_comb begin
        wr_ok             = wr_en && (wr_be == 2'b11) && hit;
        wr_cmd.clr_csc    = wr_data[B_CSC];
        wr_cmd.clr_enc    = wr_data[B_ENC];
        wr_cmd.enable     = wr_data[B_EN];
        wr_cmd.hold_reset = wr_data[B_RST];
        wr_cmd.suspend    = wr_data[B_SUSP];
    end

    assign unused_wr_bits = ^{wr_data[15:13], wr_data[11:10], wr_data[8:4], wr_data[0]};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign wr_sel[p] = wr_ok && (idx == IDX_W'(p));

        hub_port_slot u_slot (
            .clk          (clk),
            .rst          (rst),
            .wr_sel       (wr_sel[p]),
            .wr_cmd       (wr_cmd),
            .phy_connect  (phy_connect[p]),
            .phy_low_speed(phy_low_speed[p]),
            .phy_dplus    (phy_dplus[p]),
            .phy_dminus   (phy_dminus[p]),
            .phy_resume   (phy_resume[p]),
            .view         (views[p]),
            .change       (change[p])
        );

        assign port_enable[p]  = views[p].enable;
        assign port_reset[p]   = views[p].hold_reset;
        assign port_suspend[p] = views[p].suspend;
    end

    assign change_any = |change;

    hub_port_rdmux #(
        .NUM_PORTS(NUM_PORTS),
        .IDX_W    (IDX_W)
    ) u_rdmux (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .hit    (hit),
        .idx    (idx),
        .views  (views),
        .rd_data(rd_data)
    );

    a_r8_partial_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_be != 2'b11) |=> ($stable(port_reset) && $stable(port_suspend)));

    a_r12_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (port_enable == '0 && change_any == 1'b0));

endmodule

// File: tb/test_hub_port_regs.sv
module test_hub_port_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [1:0]  phy_connect = '0, phy_low_speed = '0, phy_dplus = '0;
    logic [1:0]  phy_dminus = '0, phy_resume = '0;
    logic [1:0]  port_enable, port_reset, port_suspend;
    logic        change_any;

    int          total = 0;
    int          failed = 0;
    logic [15:0] rval;
    logic [15:0] held;

    always #2 clk = ~clk;

    hub_port_regs i_hub_port_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .phy_connect(phy_connect), .phy_low_speed(phy_low_speed),
        .phy_dplus(phy_dplus), .phy_dminus(phy_dminus), .phy_resume(phy_resume),
        .port_enable(port_enable), .port_reset(port_reset),
        .port_suspend(port_suspend), .change_any(change_any)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
        bus_addr = a; wr_data = d; wr_be = be; wr_en = 1'b1;
        tick();
        wr_en = 1'b0; wr_be = 2'b00;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        rval = rd_data;
    endtask

    initial begin
        #800000;
        total++; failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R12 reset state
        chk("R12", "enable after reset", {14'b0, port_enable}, 16'h0000);
        chk("R12", "change after reset", {15'b0, change_any}, 16'h0000);
        chk("R12", "rd_data after reset", rd_data, 16'h0000);
        rd(8'h10);
        chk("R12", "port0 word after reset", rval, 16'h0000);

        // R2 / R9 sweep of read-only levels on both ports (connect held 0)
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 16; v++) begin
                phy_dminus[p] = v[0]; phy_dplus[p] = v[1];
                phy_resume[p] = v[2]; phy_low_speed[p] = v[3];
                rd(8'h10 + 8'(2 * p));
                chk("R2", "read-only levels", rval,
                    {7'b0, v[3], 1'b0, v[2], v[1], v[0], 4'b0});
            end
            phy_dminus[p] = 1'b0; phy_dplus[p] = 1'b0;
            phy_resume[p] = 1'b0; phy_low_speed[p] = 1'b0;
        end

        // R3 connect sets change flag
        phy_connect[0] = 1'b1;
        tick();
        chk("R10", "change_any on connect", {15'b0, change_any}, 16'h0001);
        rd(8'h10);
        chk("R3", "connect change port0", rval, 16'h0003);
        rd(8'h12);
        chk("R3", "port1 untouched", rval, 16'h0000);

        // R4 write 0 keeps, write 1 clears
        wr(8'h10, 16'h0000, 2'b11);
        rd(8'h10);
        chk("R4", "zero write keeps flag", rval, 16'h0003);
        wr(8'h10, 16'h0002, 2'b11);
        chk("R10", "change_any cleared", {15'b0, change_any}, 16'h0000);
        rd(8'h10);
        chk("R4", "one write clears flag", rval, 16'h0001);

        // R5 enable requires connection
        wr(8'h12, 16'h0004, 2'b11);
        chk("R5", "port1 enable while disconnected", {14'b0, port_enable}, 16'h0000);
        wr(8'h10, 16'h0004, 2'b11);
        chk("R5", "port0 enable while connected", {14'b0, port_enable}, 16'h0001);
        rd(8'h10);
        chk("R5", "port0 word enabled", rval, 16'h0005);

        // R6 software disable does not flag; disconnect does
        wr(8'h10, 16'h0000, 2'b11);
        rd(8'h10);
        chk("R6", "software disable no flag", rval, 16'h0001);
        wr(8'h10, 16'h0004, 2'b11);
        phy_connect[0] = 1'b0;
        tick();
        chk("R6", "enable dropped on disconnect", {14'b0, port_enable}, 16'h0000);
        rd(8'h10);
        chk("R6", "disconnect flags", rval, 16'h000A);

        // R4 same-cycle event wins over clear
        phy_connect[0] = 1'b1;
        wr(8'h10, 16'h000A, 2'b11);
        rd(8'h10);
        chk("R4", "connect event beats clear", rval, 16'h0003);
        wr(8'h10, 16'h0006, 2'b11);
        rd(8'h10);
        chk("R4", "re-enable and clear", rval, 16'h0005);
        phy_connect[0] = 1'b0;
        wr(8'h10, 16'h0008, 2'b11);
        rd(8'h10);
        chk("R4", "enable-change event beats clear", rval, 16'h000A);
        wr(8'h10, 16'h000A, 2'b11);
        rd(8'h10);
        chk("R4", "both flags cleared", rval, 16'h0000);

        // R7 reset and suspend controls
        wr(8'h12, 16'h1200, 2'b11);
        chk("R7", "port_reset", {14'b0, port_reset}, 16'h0002);
        chk("R7", "port_suspend", {14'b0, port_suspend}, 16'h0002);
        rd(8'h12);
        chk("R7", "port1 word", rval, 16'h1200);
        wr(8'h12, 16'h0200, 2'b11);
        chk("R7", "suspend cleared", {14'b0, port_suspend}, 16'h0000);

        // R8 partial writes ignored
        wr(8'h12, 16'hFFFF, 2'b01);
        rd(8'h12);
        chk("R8", "low byte only", rval, 16'h0200);
        wr(8'h12, 16'hFFFF, 2'b10);
        rd(8'h12);
        chk("R8", "high byte only", rval, 16'h0200);

        // R1 decode: out of range and odd addresses
        wr(8'h14, 16'h1204, 2'b11);
        wr(8'h11, 16'h1204, 2'b11);
        wr(8'h0E, 16'h1204, 2'b11);
        rd(8'h10);
        chk("R1", "port0 unaffected", rval, 16'h0000);
        rd(8'h12);
        chk("R1", "port1 unaffected", rval, 16'h0200);
        rd(8'h14);
        chk("R1", "beyond range reads zero", rval, 16'h0000);
        rd(8'h0E);
        chk("R1", "below base reads zero", rval, 16'h0000);
        rd(8'h13);
        chk("R1", "odd address reads zero", rval, 16'h0000);

        // R2 / R9 all-ones write: read-only and reserved bits stay clear
        wr(8'h12, 16'hFFFF, 2'b11);
        rd(8'h12);
        chk("R9", "all-ones write", rval, 16'h1200);

        // R11 hold and no side effects
        phy_connect[1] = 1'b1;
        tick();
        chk("R10", "port1 event raises change", {15'b0, change_any}, 16'h0001);
        rd(8'h12);
        held = rval;
        chk("R11", "first read", held, 16'h1203);
        phy_dminus[1] = 1'b1;
        tick();
        chk("R11", "rd_data held without rd_en", rd_data, held);
        rd(8'h12);
        chk("R11", "second read no side effect", rval, 16'h1213);
        wr(8'h12, 16'h0002, 2'b11);
        rd(8'h12);
        chk("R11", "after clear", rval, 16'h0011);
        chk("R10", "change_any low", {15'b0, change_any}, 16'h0000);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule